// File: doc/BRIEF.md
# Run-Time Programmable Third-Order Decimation Filter

This block turns a single-bit delta-sigma modulator stream into wide signed words at a reduced rate. It is a three-stage cascaded integrator-comb filter: three running-sum integrators advance on every accepted modulator bit, and three differencing stages run once per output word. The result has a cubed-sinc low-pass response whose nulls fall at whole multiples of the output rate. That response strips the shaped quantisation noise the modulator leaves in its bitstream.

The decimation ratio is not fixed at build time. An 8-bit rate word sets it at run time, and the ratio is eight times that word. Words below 13 behave as 13, so the ratio runs from 104 to 2040. A new rate word, or a pulse on the restart input, empties the comb history and the sample counter. The block then reports, through a settled flag, when the output words are again true filter outputs.

Top module: `sinc3_decimator`

## Requirements
- R1: While reset is held, and in the cycle after its release, `result_o` is 0 and both `result_vld_o` and `settled_o` are 0.
- R2: The decimation ratio R is 8 times `rate_word_i`. Once running, `result_vld_o` pulses exactly once for every R accepted bits.
- R3: A bit value of 1 counts as +1 and a value of 0 counts as -1. With a constant stream, a settled result equals +R³ for all ones and -R³ for all zeros.
- R4: For an input repeating with a period that divides 8, a settled result equals (ones − zeros)/8 × R³ over one 8-bit period. An alternating stream therefore gives exactly 0, because it falls in a null of the response.
- R5: `result_vld_o` is high for one cycle per result, and `result_o` holds its value between pulses.
- R6: `restart_i` high at a clock edge, or any change of `rate_word_i`, clears the sample counter and the comb history. The first result after that edge follows after exactly R further accepted bits.
- R7: `settled_o` drops in the cycle after a restart or word change. It stays low through the first three results that follow, rises together with the fourth, and stays high until the next restart, word change or reset.
- R8: Bits presented with `bit_vld_i` low are ignored. They neither advance the counter nor change the result.
- R9: Rate words 0 to 12 give the same ratio as 13, i.e. R = 104.
- R10: At every ratio up to 2040, a settled result lies within ±R³ and fits the 34-bit signed output without wrapping.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bit_i | input | 1 | Modulator bit |
| bit_vld_i | input | 1 | Qualifies `bit_i` for this cycle |
| rate_word_i | input | 8 | Decimation word, ratio = 8 × word (minimum word 13) |
| restart_i | input | 1 | Clears counter and comb history |
| result_o | output | 34 | Signed decimated result |
| result_vld_o | output | 1 | One-cycle strobe for a new result |
| settled_o | output | 1 | High once the comb history holds only post-restart data |

## Verification
The bench goes after these corner cases:
- Ratios below the floor. A design that did not clamp would emit results after far fewer than 104 bits and break the spacing checks.
- The largest ratio, 2040. A narrow datapath would wrap and return a negative value for an all-ones stream.
- Gapped input, with junk bit values presented while the qualifier is low. A design that counted or integrated those cycles would produce results with the wrong spacing and the wrong level.
- A restart that comes from a word change alone. A design that missed it would give the wrong first-result latency.
- The settled flag after a restart. A flag raised after two or three results, instead of with the fourth, is caught as soon as that early result arrives.

// File: rtl/sinc3_pkg.sv
package sinc3_pkg;
    localparam int ORDER     = 3;
    localparam int ACC_W     = 34;
    localparam int WORD_W    = 8;
    localparam int SHIFT     = 3;
    localparam int MIN_WORD  = 13;
    localparam int RATIO_W   = WORD_W + SHIFT;
    localparam int HIST_W    = $clog2(ORDER + 1);

    typedef logic signed [ACC_W-1:0] acc_t;
    typedef logic [RATIO_W-1:0]      ratio_t;
    typedef logic [WORD_W-1:0]       word_t;

    localparam acc_t STEP_UP   = acc_t'(1);
    localparam acc_t STEP_DOWN = acc_t'(-1);

    // Per-decimation control handed from the rate controller to the top.
    typedef struct packed {
        logic clr;
        logic dec;
        logic hist_full;
    } ctrl_t;

    function automatic ratio_t ratio_of(input word_t w);
        word_t eff;
        eff = (w < word_t'(MIN_WORD)) ? word_t'(MIN_WORD) : w;
        return {eff, {SHIFT{1'b0}}};
    endfunction

    function automatic acc_t step_of(input logic b);
        return b ? STEP_UP : STEP_DOWN;
    endfunction
endpackage

// File: rtl/sinc3_integ.sv
module sinc3_integ
    import sinc3_pkg::*;
#(
    parameter int N_STAGE = ORDER
) (
    input  logic clk,
    input  logic rst,
    input  logic en_i,
    input  logic bit_i,
    output acc_t sum_o
);
    acc_t stage_q [N_STAGE];

    generate
        for (genvar s = 0; s < N_STAGE; s++) begin : g_stage
            if (s == 0) begin : g_first
                always_ff @(posedge clk) begin
                    if (rst)       stage_q[0] <= '0;
                    else if (en_i) stage_q[0] <= stage_q[0] + step_of(bit_i);
                end
            end else begin : g_next
                always_ff @(posedge clk) begin
                    if (rst)       stage_q[s] <= '0;
                    else if (en_i) stage_q[s] <= stage_q[s] + stage_q[s-1];
                end
            end
        end
    endgenerate

    assign sum_o = stage_q[N_STAGE-1];
endmodule

// File: rtl/sinc3_rate_ctrl.sv
module sinc3_rate_ctrl
    import sinc3_pkg::*;
#(
    parameter int N_STAGE = ORDER
) (
    input  logic   clk,
    input  logic   rst,
    input  word_t  word_i,
    input  logic   restart_i,
    input  logic   en_i,
    output ctrl_t  ctrl_o,
    output ratio_t ratio_o
);
    localparam int HW = $clog2(N_STAGE + 1);

    word_t          word_q;
    ratio_t         cnt_q;
    ratio_t         ratio;
    logic [HW-1:0]  hist_q;
    logic           clr;
    logic           last;
    logic           dec;

    assign ratio = ratio_of(word_q);
    assign clr   = restart_i || (word_i != word_q);
    assign last  = (cnt_q == ratio - ratio_t'(1));
    assign dec   = en_i && !clr && last;

    always_ff @(posedge clk) begin
        if (rst) begin
            word_q <= '0;
            cnt_q  <= '0;
            hist_q <= '0;
        end else begin
            word_q <= word_i;
            if (clr)       cnt_q <= '0;
            else if (en_i) cnt_q <= last ? '0 : cnt_q + ratio_t'(1);
            if (clr)                                   hist_q <= '0;
            else if (dec && hist_q != HW'(N_STAGE))    hist_q <= hist_q + HW'(1);
        end
    end

    assign ctrl_o.clr       = clr;
    assign ctrl_o.dec       = dec;
    assign ctrl_o.hist_full = (hist_q == HW'(N_STAGE));
    assign ratio_o          = ratio;

    p_cnt_below_ratio_r2: assert property (@(posedge clk) disable iff (rst)
        cnt_q < ratio);
    p_floor_ratio_r9: assert property (@(posedge clk) disable iff (rst)
        ratio >= ratio_t'(MIN_WORD * 8));
    p_restart_clears_r6: assert property (@(posedge clk) disable iff (rst)
        clr |=> (cnt_q == '0 && hist_q == '0));
endmodule

// File: rtl/sinc3_comb.sv
module sinc3_comb
    import sinc3_pkg::*;
#(
    parameter int N_STAGE = ORDER
) (
    input  logic clk,
    input  logic rst,
    input  logic clr_i,
    input  logic dec_i,
    input  acc_t sum_i,
    output acc_t diff_o
);
    acc_t dly_q [N_STAGE];
    acc_t tap   [N_STAGE];
    acc_t feed  [N_STAGE];

    generate
        for (genvar s = 0; s < N_STAGE; s++) begin : g_stage
            if (s == 0) begin : g_first
                assign feed[0] = sum_i;
            end else begin : g_next
                assign feed[s] = tap[s-1];
            end
            assign tap[s] = feed[s] - dly_q[s];

            always_ff @(posedge clk) begin
                if (rst || clr_i) dly_q[s] <= '0;
                else if (dec_i)   dly_q[s] <= feed[s];
            end
        end
    endgenerate

    assign diff_o = tap[N_STAGE-1];
endmodule

// File: rtl/sinc3_decimator.sv
module sinc3_decimator
    import sinc3_pkg::*;
(
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    bit_i,
    input  logic                    bit_vld_i,
    input  logic [WORD_W-1:0]       rate_word_i,
    input  logic                    restart_i,
    output logic signed [ACC_W-1:0] result_o,
    output logic                    result_vld_o,
    output logic                    settled_o
);
    acc_t   integ_sum;
    acc_t   comb_out;
    ctrl_t  ctrl;
    ratio_t ratio;

    sinc3_integ #(.N_STAGE(ORDER)) u_integ (
        .clk   (clk),
        .rst   (rst),
        .en_i  (bit_vld_i),
        .bit_i (bit_i),
        .sum_o (integ_sum)
    );

    sinc3_rate_ctrl #(.N_STAGE(ORDER)) u_ctrl (
        .clk       (clk),
        .rst       (rst),
        .word_i    (rate_word_i),
        .restart_i (restart_i),
        .en_i      (bit_vld_i),
        .ctrl_o    (ctrl),
        .ratio_o   (ratio)
    );

    sinc3_comb #(.N_STAGE(ORDER)) u_comb (
        .clk    (clk),
        .rst    (rst),
        .clr_i  (ctrl.clr),
        .dec_i  (ctrl.dec),
        .sum_i  (integ_sum),
        .diff_o (comb_out)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            result_o     <= '0;
            result_vld_o <= 1'b0;
            settled_o    <= 1'b0;
        end else begin
            result_vld_o <= ctrl.dec;
            if (ctrl.dec) result_o <= comb_out;
            if (ctrl.clr)                         settled_o <= 1'b0;
            else if (ctrl.dec && ctrl.hist_full)  settled_o <= 1'b1;
        end
    end

    logic signed [63:0] ratio_ext;
    logic signed [63:0] cube;
    logic signed [63:0] res_ext;
    assign ratio_ext = $signed({{(64-RATIO_W){1'b0}}, ratio});
    assign cube      = ratio_ext * ratio_ext * ratio_ext;
    assign res_ext   = {{(64-ACC_W){result_o[ACC_W-1]}}, result_o};

    p_vld_single_r5: assert property (@(posedge clk) disable iff (rst)
        result_vld_o |=> !result_vld_o);
    p_hold_result_r5: assert property (@(posedge clk) disable iff (rst)
        (!result_vld_o && !$past(rst)) |-> $stable(result_o));
    p_settle_with_result_r7: assert property (@(posedge clk) disable iff (rst)
        $rose(settled_o) |-> result_vld_o);
    p_restart_drops_r7: assert property (@(posedge clk) disable iff (rst)
        restart_i |=> !settled_o);
    p_no_overflow_r10: assert property (@(posedge clk) disable iff (rst)
        (result_vld_o && settled_o) |-> (res_ext <= cube && res_ext >= -cube));
endmodule

// File: tb/sinc3_decimator_tb_top.sv
module sinc3_decimator_tb_top;
    import sinc3_pkg::*;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic bit_in = 1'b0;
    logic vld = 1'b0;
    logic [WORD_W-1:0] word = 8'd13;
    logic restart = 1'b0;
    logic signed [ACC_W-1:0] result;
    logic result_vld;
    logic settled;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    always #2.5 clk = ~clk;

    sinc3_decimator dut_i (
        .clk          (clk),
        .rst          (rst),
        .bit_i        (bit_in),
        .bit_vld_i    (vld),
        .rate_word_i  (word),
        .restart_i    (restart),
        .result_o     (result),
        .result_vld_o (result_vld),
        .settled_o    (settled)
    );

    typedef struct packed {
        logic [7:0] w;
        logic [7:0] pat;
        logic [1:0] gap;
        logic       use_rst;
    } vec_t;

    // Stimulus table. The expected level is derived from the word and pattern.
    localparam int NV = 8;
    localparam vec_t VECS [NV] = '{
        '{8'd13,  8'hFF, 2'd1, 1'b1},
        '{8'd20,  8'h00, 2'd1, 1'b0},
        '{8'd16,  8'h55, 2'd1, 1'b1},
        '{8'd13,  8'h77, 2'd1, 1'b0},
        '{8'd5,   8'hFF, 2'd2, 1'b1},
        '{8'd0,   8'h01, 2'd1, 1'b0},
        '{8'd255, 8'hFF, 2'd1, 1'b1},
        '{8'd100, 8'h0F, 2'd2, 1'b0}
    };

    task automatic check(input bit ok, input string tag, input longint got, input longint exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s got=%0d expected=%0d", tag, got, exp);
        end
    endtask

    task automatic run_vec(input vec_t v);
        longint r, expv;
        int ones, pulses, since, last, k;
        bit stable_ok;
        logic signed [ACC_W-1:0] held;
        string vtag;
        r      = 8 * ((v.w < 8'd13) ? 13 : int'(v.w));
        ones   = $countones(v.pat);
        expv   = ((2 * ones - 8) * r * r * r) / 8;
        vtag   = (v.pat == 8'hFF || v.pat == 8'h00) ? "R3" : "R4";
        pulses = 0; since = 0; last = 0; stable_ok = 1'b1; held = '0;
        @(negedge clk);
        word    = v.w;
        restart = v.use_rst;
        vld     = 1'b1;
        bit_in  = v.pat[0];
        k       = 1;
        while (pulses < 6) begin
            @(negedge clk);
            since++;
            restart = 1'b0;
            if (result_vld) begin
                pulses++;
                check(settled == (pulses >= 4), "R7 settled vs result index",
                      longint'(settled), longint'(pulses >= 4));
                if (pulses == 1)
                    check(since == r * v.gap + 1, "R6 first result latency",
                          since, r * v.gap + 1);
                else
                    check(since - last == r * v.gap,
                          (v.gap > 1) ? "R8 spacing with gapped input" : "R2 result spacing",
                          since - last, r * v.gap);
                if (pulses >= 2)
                    check(stable_ok, "R5 result held between strobes", 0, 1);
                if (pulses >= 4)
                    check(longint'(result) == expv, vtag, longint'(result), expv);
                last = since; held = result; stable_ok = 1'b1;
            end else if (pulses > 0 && result !== held) begin
                stable_ok = 1'b0;
            end
            if (since % v.gap == 0) begin
                vld = 1'b1; bit_in = v.pat[k % 8]; k++;
            end else begin
                vld = 1'b0; bit_in = ~v.pat[k % 8];
            end
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog expired got=0 expected=1");
            $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (4) @(negedge clk);
        check(result == '0 && !result_vld && !settled, "R1 reset state",
              longint'(result), 0);
        rst = 1'b0;
        @(negedge clk);
        check(result == '0 && !result_vld && !settled, "R1 after release",
              longint'({result_vld, settled}), 0);

        for (int i = 0; i < NV; i++) begin
            run_vec(VECS[i]);
        end

        // R9: words 5 and 0 use ratio 104, covered by spacing checks above.
        // R10: ratio 2040 with all ones gives 2040^3 without wrapping.

        // R7: restart while settled drops the flag at the next edge.
        check(settled == 1'b1, "R7 settled before restart", longint'(settled), 1);
        @(negedge clk);
        restart = 1'b1;
        vld     = 1'b0;
        @(negedge clk);
        restart = 1'b0;
        check(settled == 1'b0, "R7 settled cleared by restart", longint'(settled), 0);
        check(result_vld == 1'b0, "R6 no strobe on restart", longint'(result_vld), 0);

        // R8: with the qualifier held low no result appears.
        bit_in = 1'b1;
        repeat (1000) @(negedge clk);
        check(result_vld == 1'b0 && settled == 1'b0, "R8 idle without qualified bits",
              longint'({result_vld, settled}), 0);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
        $finish;
    end
endmodule